// File: doc/BRIEF.md
# Open-Drain Two-Line Pin Controller

This block gives software direct control of the two wires of a two-wire serial bus: a clock line and a data line. Software toggles these wires itself to produce bus traffic. Each line is open-drain. The block can only pull a pad low. When it releases a pad, an external pull-up raises the line. The block itself never drives a pad high.

Each line has three writable controls:
- an ownership bit, which hands the pad to software;
- an output level;
- a driver enable.

Each line also has a read-only level bit. That bit is fed from the pad through a two-flop synchroniser. While a line's ownership bit is clear, a second owner controls that pad through a dedicated input. The usual sequence is: clear the output levels, clear both enables, then set the ownership bits. After that, software pulls a line low by setting its enable and lets it go by clearing the enable.

Top module: `odpin_ctrl`

## Requirements
- R1: After reset, every register reads 0 and neither pad is pulled low while the second-owner input is 0.
- R2: Register addresses are: 0 ownership, 1 output level, 2 driver enable, 3 pad level (read-only). In every register, bit 0 is the clock line and bit 1 is the data line. A write at address 0, 1 or 2 takes effect at the next rising clock edge, and a read of that address returns the value just written.
- R3: When a line is software-owned and its output level is 0, the line's pull-low output follows its enable bit. The two lines are independent of each other.
- R4: When a line is software-owned and its output level is 1, the line is never pulled low, whatever its enable bit holds.
- R5: When a line is not software-owned, its pull-low output equals the second-owner input for that line. The software output level and enable have no effect on it.
- R6: The pad-level register reads 1 when the pad is high and 0 when it is low. It reflects a pad change three rising edges after the change: two synchroniser stages, then the register.
- R7: A write to address 3 changes no register.
- R8: Ownership bits are per line. Software can own one line while the second owner keeps the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 2 | Write data, bit 0 clock line, bit 1 data line |
| reg_rdata | output | 2 | Read data for reg_addr (combinational) |
| alt_pull_low | input | 2 | Second owner's pull-low request per line |
| pad_level | input | 2 | Level sensed on each pad |
| pad_pull_low | output | 2 | Open-drain pull-low per pad |

## Verification
Two events can coincide here: an ownership hand-over, and the pad already being held low by the outgoing owner. The bench arranges that collision deliberately. Software pre-loads enable = 1 and output = 0 while the second owner is holding the clock line low. The ownership write then lands on the same edge at which the second owner lets go. The hand-over passes if the pull-low output stays asserted in every sampled cycle and the synchronised pad level never reads high.

// File: rtl/odpin_pkg.sv
package odpin_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_OWN  = 2'd0,
    A_LVL  = 2'd1,
    A_DRV  = 2'd2,
    A_PAD  = 2'd3
  } odp_addr_e;

  // Open-drain pull decision for one line.
  function automatic logic line_pulls(input logic sw_own, input logic sw_lvl,
                                      input logic sw_drv, input logic alt_pull);
    if (sw_own) return sw_drv & ~sw_lvl;
    return alt_pull;
  endfunction
endpackage

// File: rtl/odp_regfile.sv
module odp_regfile
  import odpin_pkg::*;
#(
  parameter int LINES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LINES-1:0]  wdata,
  input  logic [LINES-1:0]  pad_bits,
  output logic [LINES-1:0]  rdata,
  output logic [LINES-1:0]  own_q,
  output logic [LINES-1:0]  lvl_q,
  output logic [LINES-1:0]  drv_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= '0;
      lvl_q <= '0;
      drv_q <= '0;
    end else if (wr) begin
      case (odp_addr_e'(addr))
        A_OWN:   own_q <= wdata;
        A_LVL:   lvl_q <= wdata;
        A_DRV:   drv_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (odp_addr_e'(addr))
      A_OWN:   rdata = own_q;
      A_LVL:   rdata = lvl_q;
      A_DRV:   rdata = drv_q;
      default: rdata = pad_bits;
    endcase
  end
endmodule

// File: rtl/odp_sync.sv
module odp_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pad_level,
  output logic [LINES-1:0] pad_bits
);
  localparam int LAST = STAGES - 1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain       <= '0;
        pad_bits[g] <= 1'b0;
      end else begin
        chain       <= {chain[STAGES-2:0], pad_level[g]};
        pad_bits[g] <= (chain[LAST] != 1'b0);
      end
    end
  end
endmodule

// File: rtl/odp_pad_drive.sv
module odp_pad_drive
  import odpin_pkg::*;
#(
  parameter int LINES = 2
) (
  input  logic [LINES-1:0] own_q,
  input  logic [LINES-1:0] lvl_q,
  input  logic [LINES-1:0] drv_q,
  input  logic [LINES-1:0] alt_pull_low,
  output logic [LINES-1:0] pad_pull_low
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign pad_pull_low[g] = line_pulls(own_q[g], lvl_q[g], drv_q[g], alt_pull_low[g]);
  end
endmodule

// File: rtl/odpin_ctrl.sv
module odpin_ctrl
  import odpin_pkg::*;
#(
  parameter int LINES       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [LINES-1:0]  reg_wdata,
  output logic [LINES-1:0]  reg_rdata,
  input  logic [LINES-1:0]  alt_pull_low,
  input  logic [LINES-1:0]  pad_level,
  output logic [LINES-1:0]  pad_pull_low
);
  // Named internal wires, visible to the bound checker.
  logic [LINES-1:0] own_q;
  logic [LINES-1:0] lvl_q;
  logic [LINES-1:0] drv_q;
  logic [LINES-1:0] pad_bits;

  odp_regfile #(.LINES(LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .pad_bits(pad_bits), .rdata(reg_rdata),
    .own_q(own_q), .lvl_q(lvl_q), .drv_q(drv_q)
  );

  odp_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_level(pad_level), .pad_bits(pad_bits)
  );

  odp_pad_drive #(.LINES(LINES)) u_drive (
    .own_q(own_q), .lvl_q(lvl_q), .drv_q(drv_q),
    .alt_pull_low(alt_pull_low), .pad_pull_low(pad_pull_low)
  );
endmodule

// File: rtl/odpin_ctrl_chk.sv
module odpin_ctrl_chk
  import odpin_pkg::*;
#(
  parameter int LINES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [LINES-1:0]  reg_wdata,
  input logic [LINES-1:0]  alt_pull_low,
  input logic [LINES-1:0]  pad_level,
  input logic [LINES-1:0]  pad_pull_low,
  input logic [LINES-1:0]  own_q,
  input logic [LINES-1:0]  lvl_q,
  input logic [LINES-1:0]  drv_q,
  input logic [LINES-1:0]  pad_bits
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R3: enabling both lines while software-owned with level 0 pulls them low next cycle
  p_drive_follows_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_DRV && own_q == '1 && lvl_q == '0) |=> (pad_pull_low == $past(reg_wdata)));

  // R4
  p_high_level_never_pulls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pull_low & own_q & lvl_q) == '0));

  // R5
  p_alt_owner_passthru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == '0) |-> (pad_pull_low == alt_pull_low));

  // R6
  p_pad_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (pad_bits == $past(pad_level, 3)));

  // R7
  p_pad_addr_readonly_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_PAD) |=> ($stable(own_q) && $stable(lvl_q) && $stable(drv_q)));
endmodule

bind odpin_ctrl odpin_ctrl_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .alt_pull_low(alt_pull_low), .pad_level(pad_level),
  .pad_pull_low(pad_pull_low), .own_q(own_q), .lvl_q(lvl_q), .drv_q(drv_q),
  .pad_bits(pad_bits)
);

// File: tb/test_odpin_ctrl.sv
module test_odpin_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [1:0] reg_wdata = 2'd0;
  logic [1:0] reg_rdata;
  logic [1:0] alt_pull_low = 2'b00;
  logic [1:0] ext_low = 2'b00;
  logic [1:0] pad_level;
  logic [1:0] pad_pull_low;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  // Open-drain wire with external pull-up.
  assign pad_level = ~(pad_pull_low | ext_low);

  odpin_ctrl i_odpin_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alt_pull_low(alt_pull_low),
    .pad_level(pad_level), .pad_pull_low(pad_pull_low)
  );

  function automatic logic [1:0] exp_pull(input logic [1:0] own, input logic [1:0] lvl,
                                          input logic [1:0] drv, input logic [1:0] alt);
    logic [1:0] r;
    for (int i = 0; i < 2; i++) r[i] = own[i] ? (drv[i] && !lvl[i]) : alt[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [1:0] v;
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), v);
      check("R1 reg", v, 2'b00);
    end
    check("R1 pull", pad_pull_low, 2'b00);
  endtask

  task automatic t_readback;
    logic [1:0] v;
    wr(2'd1, 2'b10); rd(2'd1, v); check("R2 lvl", v, 2'b10);
    wr(2'd2, 2'b01); rd(2'd2, v); check("R2 drv", v, 2'b01);
    wr(2'd0, 2'b11); rd(2'd0, v); check("R2 own", v, 2'b11);
    wr(2'd0, 2'b00); rd(2'd0, v); check("R2 own clr", v, 2'b00);
    wr(2'd1, 2'b00); wr(2'd2, 2'b00);
  endtask

  task automatic t_sw_drive;
    wr(2'd0, 2'b11);
    wr(2'd2, 2'b01); #1 check("R3 clk low", pad_pull_low, 2'b01);
    wr(2'd2, 2'b10); #1 check("R3 data low", pad_pull_low, 2'b10);
    wr(2'd2, 2'b00); #1 check("R3 release", pad_pull_low, 2'b00);
  endtask

  task automatic t_high_level;
    wr(2'd1, 2'b11);
    wr(2'd2, 2'b11); #1 check("R4 no pull", pad_pull_low, 2'b00);
    wr(2'd1, 2'b01); #1 check("R4 mixed", pad_pull_low, exp_pull(2'b11, 2'b01, 2'b11, 2'b00));
    wr(2'd2, 2'b00); wr(2'd1, 2'b00);
  endtask

  task automatic t_alt_owner;
    wr(2'd0, 2'b00);
    wr(2'd2, 2'b11);
    @(negedge clk); alt_pull_low = 2'b10;
    #1 check("R5 alt follows", pad_pull_low, 2'b10);
    @(negedge clk); alt_pull_low = 2'b01;
    #1 check("R5 alt follows 2", pad_pull_low, 2'b01);
    wr(2'd0, 2'b10);
    #1 check("R8 split own", pad_pull_low, exp_pull(2'b10, 2'b00, 2'b11, 2'b01));
    @(negedge clk); alt_pull_low = 2'b00;
    wr(2'd2, 2'b00); wr(2'd0, 2'b00);
  endtask

  task automatic t_pad_sync;
    logic [1:0] v;
    rd(2'd3, v); check("R6 idle high", v, 2'b11);
    ext_low = 2'b10;
    @(posedge clk); @(posedge clk); #1 check("R6 not yet", reg_rdata, 2'b11);
    @(posedge clk); #1 check("R6 third edge", reg_rdata, 2'b01);
    @(negedge clk); ext_low = 2'b00;
    repeat (3) @(posedge clk);
    #1 check("R6 back high", reg_rdata, 2'b11);
  endtask

  task automatic t_readonly;
    logic [1:0] v;
    wr(2'd1, 2'b01); wr(2'd2, 2'b10); wr(2'd0, 2'b01);
    wr(2'd3, 2'b10);
    rd(2'd0, v); check("R7 own kept", v, 2'b01);
    rd(2'd1, v); check("R7 lvl kept", v, 2'b01);
    rd(2'd2, v); check("R7 drv kept", v, 2'b10);
    wr(2'd0, 2'b00); wr(2'd1, 2'b00); wr(2'd2, 2'b00);
  endtask

  task automatic t_handover;
    @(negedge clk); alt_pull_low = 2'b01;
    wr(2'd2, 2'b01);
    repeat (4) @(negedge clk);
    reg_addr = 2'd3;
    #1 check("R8 pre low", reg_rdata, 2'b10);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 2'b01;
    #1 check("R8 before edge", pad_pull_low, 2'b01);
    @(posedge clk); #1 alt_pull_low = 2'b00;
    check("R8 after edge", pad_pull_low, 2'b01);
    @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd3;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      check("R8 held", pad_pull_low, 2'b01);
      check("R8 pad stays low", reg_rdata, 2'b10);
    end
    wr(2'd2, 2'b00); wr(2'd0, 2'b00);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_sw_drive();
    t_high_level();
    t_alt_owner();
    t_pad_sync();
    t_readonly();
    t_handover();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule